// File: doc/BRIEF.md
# ALU Signature Sweeper

This block drives an ALU through a fixed, exhaustive set of operand and flag vectors and boils each instruction's responses down to a single 32-bit signature. Once started, it walks a range of opcodes. For every opcode it applies each pair of values from an eight-entry operand table under all four input flag settings, which gives 256 vectors per opcode. It folds each returned result word, carry and zero into a CRC-32. The result is one number per instruction that a host or a golden table can compare, in place of a log of 256 lines.

The block presents each vector for one cycle. It expects the ALU to return the matching response exactly one cycle later. When an opcode's last response has been absorbed, the block pulses a strobe that carries the opcode and its signature. At that moment the expected signature for that opcode must be present on the expected-signature input. Any difference sets a sticky mismatch flag. After the final opcode's signature, `done` rises and stays high until the next accepted start.

Top module: `alu_sig_sweeper`

## Requirements
- R1: While reset is held, and until the first accepted start, every output is zero: the stimulus buses and flags, `sig_valid`, `sig_op`, `sig_value`, `mismatch` and `done`.
- R2: A `start` sampled high while idle or done begins a sweep. In the cycle after the accepting edge, and in every following cycle for 256 cycles per opcode, the block presents one vector. Opcodes run in ascending order from FIRST_OP (default 8) to LAST_OP (default 63).
- R3: Within one opcode, the vector order is as follows. The S table index (0..7) is the slowest counter and the D table index is the middle counter. The flag pair (C,Z) is the fastest and cycles through 00, 01, 10, 11 in that order, so vector n uses S index n/32, D index (n/4)%8, C = bit 1 of n and Z = bit 0 of n.
- R4: Operand table entries 0..7 are 0, 1, 2, 0x7FFFFFFF, 0x80000000, 0x80000001, 0xFFFFFFFE and 0xFFFFFFFF, and this table applies to both `alu_s` and `alu_d`.
- R5: The response (`alu_q`, `alu_cout`, `alu_zout`) for a vector presented in cycle k is taken from cycle k+1.
- R6: Each signature is computed as follows. The CRC register is set to 0xFFFFFFFF at each opcode's first vector. For each vector it shifts in 34 bits, least significant first, using the reflected polynomial 0xEDB88320: result bits 0 to 31, then carry, then zero. The signature is the bitwise inverse of the final register.
- R7: `sig_valid` is high for exactly one cycle, two cycles after an opcode's last vector is presented, with `sig_op` and `sig_value` holding that opcode and its signature.
- R8: `mismatch` rises in the cycle after a `sig_valid` cycle in which `sig_value` differs from `exp_sig`. It then stays high until a start is accepted, and the accepting edge clears it.
- R9: `done` rises three cycles after the last vector of LAST_OP and stays high until a start is accepted.
- R10: A `start` pulse during a sweep, including the trailing cycles before `done`, is ignored: the vector stream and the signatures continue unchanged.
- R11: Outside a sweep's vector cycles, `alu_op`, `alu_s`, `alu_d`, `alu_cin` and `alu_zin` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a sweep when idle or done |
| alu_op | output | 6 | Opcode applied to the ALU |
| alu_s | output | 32 | Source operand |
| alu_d | output | 32 | Destination operand |
| alu_cin | output | 1 | Carry flag input to the ALU |
| alu_zin | output | 1 | Zero flag input to the ALU |
| alu_q | input | 32 | ALU result, one cycle after the vector |
| alu_cout | input | 1 | ALU carry out |
| alu_zout | input | 1 | ALU zero out |
| exp_sig | input | 32 | Expected signature for `sig_op`, read while `sig_valid` is high |
| sig_valid | output | 1 | One-cycle strobe for a finished opcode |
| sig_op | output | 6 | Opcode of the signature |
| sig_value | output | 32 | Opcode signature |
| mismatch | output | 1 | Sticky signature-difference flag |
| done | output | 1 | Sweep complete |

## Verification
The bench attacks the one-cycle response alignment. A block that took the response from the wrong cycle would fold in a neighbouring vector's result, so every signature would differ from the reference. The CRC re-seed at each opcode boundary is checked from the second opcode onward, because carrying the first opcode's state forward would break every later signature. A corrupted expectation on the last opcode checks that `mismatch` has settled by the time `done` rises. A second corruption on an earlier opcode, followed by a clean sweep, checks that the flag is sticky and that it clears at the next accepted start. A start pulse in the middle of a sweep checks that a block which restarted on it would reset its counters and shift the vector stream.

// File: rtl/alusig_pkg.sv
package alusig_pkg;

  localparam int          CRC_W    = 32;
  localparam logic [31:0] CRC_POLY = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED = 32'hFFFFFFFF;

  // Operand table: eight entries, selected by a three-bit index
  localparam int TBL_N    = 8;
  localparam int TBL_IDXW = $clog2(TBL_N);

  // Flag pair per operand pair (C,Z)
  localparam int FLAG_W = 2;

  typedef enum logic [1:0] {
    SW_IDLE  = 2'd0,
    SW_RUN   = 2'd1,
    SW_DRAIN = 2'd2,
    SW_DONE  = 2'd3
  } sweep_st_e;

endpackage

// File: rtl/alusig_optbl.sv
module alusig_optbl #(
  parameter int DW   = 32,
  parameter int IDXW = 3
) (
  input  logic [IDXW-1:0] idx,
  output logic [DW-1:0]   val
);

  always_comb begin
    case (idx)
      3'd0:    val = '0;
      3'd1:    val = DW'(1);
      3'd2:    val = DW'(2);
      3'd3:    val = {1'b0, {(DW-1){1'b1}}};
      3'd4:    val = {1'b1, {(DW-1){1'b0}}};
      3'd5:    val = {1'b1, {(DW-2){1'b0}}, 1'b1};
      3'd6:    val = {{(DW-1){1'b1}}, 1'b0};
      default: val = '1;
    endcase
  end

endmodule

// File: rtl/alusig_seq.sv
module alusig_seq
  import alusig_pkg::*;
#(
  parameter int OPW      = 6,
  parameter int FIRST_OP = 8,
  parameter int LAST_OP  = 63,
  parameter int VW       = 2 * TBL_IDXW + FLAG_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           sig_fin,
  output logic           run,
  output logic           accept,
  output logic [OPW-1:0] op,
  output logic [VW-1:0]  vec,
  output logic           vec_first,
  output logic           vec_last,
  output logic           done
);

  localparam logic [OPW-1:0] OP_LO = OPW'(FIRST_OP);
  localparam logic [OPW-1:0] OP_HI = OPW'(LAST_OP);

  sweep_st_e      st_q, st_d;
  logic [OPW-1:0] op_q, op_d;
  logic [VW-1:0]  vec_q, vec_d;
  logic           cnt_en;
  logic           at_last_vec;
  logic           at_last_op;

  assign at_last_vec = &vec_q;
  assign at_last_op  = (op_q == OP_HI);
  assign accept      = start && ((st_q == SW_IDLE) || (st_q == SW_DONE));
  assign cnt_en      = accept || (st_q == SW_RUN);

  // Next-state process
  always_comb begin
    st_d  = st_q;
    op_d  = op_q;
    vec_d = vec_q;
    case (st_q)
      SW_IDLE, SW_DONE: begin
        if (accept) begin
          st_d  = SW_RUN;
          op_d  = OP_LO;
          vec_d = '0;
        end
      end
      SW_RUN: begin
        vec_d = vec_q + 1'b1;
        if (at_last_vec) begin
          if (at_last_op) st_d = SW_DRAIN;
          else            op_d = op_q + 1'b1;
        end
      end
      SW_DRAIN: begin
        if (sig_fin) st_d = SW_DONE;
      end
      default: st_d = SW_IDLE;
    endcase
  end

  // State register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SW_IDLE;
    else        st_q <= st_d;
  end

  // Counter registers with explicit enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= '0;
      vec_q <= '0;
    end else if (cnt_en) begin
      op_q  <= op_d;
      vec_q <= vec_d;
    end
  end

  assign run       = (st_q == SW_RUN);
  assign op        = op_q;
  assign vec       = vec_q;
  assign vec_first = (vec_q == '0);
  assign vec_last  = at_last_vec;
  assign done      = (st_q == SW_DONE);

endmodule

// File: rtl/alusig_crc.sv
module alusig_crc
  import alusig_pkg::*;
#(
  parameter int DW  = 32,
  parameter int OPW = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tag_vld,
  input  logic             tag_first,
  input  logic             tag_last,
  input  logic [OPW-1:0]   tag_op,
  input  logic [DW-1:0]    rsp_q,
  input  logic             rsp_c,
  input  logic             rsp_z,
  output logic             sig_vld,
  output logic [OPW-1:0]   sig_op,
  output logic [CRC_W-1:0] sig_val
);

  localparam int AW = DW + 2;

  // Serial reflected CRC over AW bits, bit 0 first, unrolled
  function automatic logic [CRC_W-1:0] absorb(input logic [CRC_W-1:0] cur,
                                              input logic [AW-1:0]    bits);
    logic [CRC_W-1:0] r;
    r = cur;
    for (int i = 0; i < AW; i++) begin
      if (r[0] ^ bits[i]) r = (r >> 1) ^ CRC_POLY;
      else                r = r >> 1;
    end
    return r;
  endfunction

  // Stage 1: tags delayed to line up with the ALU response
  logic             vld_q, first_q, last_q;
  logic [OPW-1:0]   op_q;
  // Stage 2: accumulator and signature
  logic [CRC_W-1:0] crc_q, crc_d;
  logic [CRC_W-1:0] base;
  logic             sv_q, sv_d;
  logic [OPW-1:0]   so_q, so_d;
  logic [CRC_W-1:0] sg_q, sg_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      first_q <= 1'b0;
      last_q  <= 1'b0;
      op_q    <= '0;
    end else begin
      vld_q   <= tag_vld;
      first_q <= tag_first;
      last_q  <= tag_last;
      op_q    <= tag_op;
    end
  end

  assign base = first_q ? CRC_SEED : crc_q;

  always_comb begin
    crc_d = crc_q;
    sv_d  = 1'b0;
    so_d  = so_q;
    sg_d  = sg_q;
    if (vld_q) begin
      crc_d = absorb(base, {rsp_z, rsp_c, rsp_q});
      if (last_q) begin
        sv_d = 1'b1;
        so_d = op_q;
        sg_d = ~crc_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= CRC_SEED;
      sv_q  <= 1'b0;
      so_q  <= '0;
      sg_q  <= '0;
    end else begin
      crc_q <= crc_d;
      sv_q  <= sv_d;
      so_q  <= so_d;
      sg_q  <= sg_d;
    end
  end

  assign sig_vld = sv_q;
  assign sig_op  = so_q;
  assign sig_val = sg_q;

endmodule

// File: rtl/alusig_cmp.sv
module alusig_cmp
  import alusig_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             sig_vld,
  input  logic [CRC_W-1:0] sig_val,
  input  logic [CRC_W-1:0] exp_val,
  output logic             miss
);

  logic miss_q, miss_d;

  always_comb begin
    miss_d = miss_q;
    if (clr)                                miss_d = 1'b0;
    else if (sig_vld && (sig_val != exp_val)) miss_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) miss_q <= 1'b0;
    else        miss_q <= miss_d;
  end

  assign miss = miss_q;

endmodule

// File: rtl/alu_sig_sweeper.sv
module alu_sig_sweeper
  import alusig_pkg::*;
#(
  parameter int DW       = 32,
  parameter int OPW      = 6,
  parameter int FIRST_OP = 8,
  parameter int LAST_OP  = 63
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic [OPW-1:0]   alu_op,
  output logic [DW-1:0]    alu_s,
  output logic [DW-1:0]    alu_d,
  output logic             alu_cin,
  output logic             alu_zin,
  input  logic [DW-1:0]    alu_q,
  input  logic             alu_cout,
  input  logic             alu_zout,
  input  logic [CRC_W-1:0] exp_sig,
  output logic             sig_valid,
  output logic [OPW-1:0]   sig_op,
  output logic [CRC_W-1:0] sig_value,
  output logic             mismatch,
  output logic             done
);

  localparam int VW = 2 * TBL_IDXW + FLAG_W;

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic           run, accept, vfirst, vlast, sig_fin;
  logic [OPW-1:0] op;
  logic [VW-1:0]  vec;
  logic [DW-1:0]  s_val, d_val;

  alusig_seq #(
    .OPW(OPW), .FIRST_OP(FIRST_OP), .LAST_OP(LAST_OP), .VW(VW)
  ) u_seq (
    .clk(clk), .rst_n(rst_int_n), .start(start), .sig_fin(sig_fin),
    .run(run), .accept(accept), .op(op), .vec(vec),
    .vec_first(vfirst), .vec_last(vlast), .done(done)
  );

  alusig_optbl #(.DW(DW), .IDXW(TBL_IDXW)) u_tbl_s (
    .idx(vec[VW-1 -: TBL_IDXW]), .val(s_val)
  );

  alusig_optbl #(.DW(DW), .IDXW(TBL_IDXW)) u_tbl_d (
    .idx(vec[FLAG_W +: TBL_IDXW]), .val(d_val)
  );

  assign alu_op  = run ? op    : '0;
  assign alu_s   = run ? s_val : '0;
  assign alu_d   = run ? d_val : '0;
  assign alu_cin = run & vec[1];
  assign alu_zin = run & vec[0];

  alusig_crc #(.DW(DW), .OPW(OPW)) u_crc (
    .clk(clk), .rst_n(rst_int_n),
    .tag_vld(run), .tag_first(vfirst), .tag_last(vlast), .tag_op(op),
    .rsp_q(alu_q), .rsp_c(alu_cout), .rsp_z(alu_zout),
    .sig_vld(sig_valid), .sig_op(sig_op), .sig_val(sig_value)
  );

  assign sig_fin = sig_valid && (sig_op == OPW'(LAST_OP));

  alusig_cmp u_cmp (
    .clk(clk), .rst_n(rst_int_n), .clr(accept),
    .sig_vld(sig_valid), .sig_val(sig_value), .exp_val(exp_sig),
    .miss(mismatch)
  );

endmodule

// File: rtl/alu_sig_sweeper_chk.sv
module alu_sig_sweeper_chk #(
  parameter int DW       = 32,
  parameter int OPW      = 6,
  parameter int FIRST_OP = 8,
  parameter int LAST_OP  = 63
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic [OPW-1:0] alu_op,
  input logic [DW-1:0]  alu_s,
  input logic [DW-1:0]  alu_d,
  input logic           alu_cin,
  input logic           alu_zin,
  input logic [31:0]    exp_sig,
  input logic           sig_valid,
  input logic [31:0]    sig_value,
  input logic           mismatch,
  input logic           done
);

  // R7
  sig_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sig_valid |=> !sig_valid);

  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  // R8
  mismatch_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mismatch && !start) |=> mismatch);

  // R8
  mismatch_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mismatch) |-> ($past(sig_valid) && ($past(sig_value) != $past(exp_sig))));

  // R2
  op_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_op != '0) |-> ((alu_op >= OPW'(FIRST_OP)) && (alu_op <= OPW'(LAST_OP))));

  // R2
  op_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((alu_op != '0) && ($past(alu_op) != '0)) |->
      ((alu_op == $past(alu_op)) || (alu_op == $past(alu_op) + 1'b1)));

  // R11
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((alu_op == '0) && (alu_s == '0) && (alu_d == '0) && !alu_cin && !alu_zin));

endmodule

bind alu_sig_sweeper alu_sig_sweeper_chk #(
  .DW(DW), .OPW(OPW), .FIRST_OP(FIRST_OP), .LAST_OP(LAST_OP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .alu_op(alu_op), .alu_s(alu_s),
  .alu_d(alu_d), .alu_cin(alu_cin), .alu_zin(alu_zin), .exp_sig(exp_sig),
  .sig_valid(sig_valid), .sig_value(sig_value), .mismatch(mismatch), .done(done)
);

// File: tb/alu_sig_sweeper_bench.sv
`timescale 1ns/1ps
module alu_sig_sweeper_bench;

  localparam int FIRST = 8;
  localparam int LAST  = 63;
  localparam int NOPS  = LAST - FIRST + 1;
  localparam int VPO   = 256;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [5:0]  alu_op;
  logic [31:0] alu_s, alu_d;
  logic        alu_cin, alu_zin;
  logic [31:0] alu_q;
  logic        alu_cout, alu_zout;
  logic [31:0] exp_sig;
  logic        sig_valid;
  logic [5:0]  sig_op;
  logic [31:0] sig_value;
  logic        mismatch, done;

  int checks = 0;
  int errors = 0;
  int corrupt = -1;
  bit finished = 0;
  logic [31:0] gold [64];

  always #2.5 clk = ~clk;

  alu_sig_sweeper u_alu_sig_sweeper (
    .clk(clk), .rst_n(rst_n), .start(start),
    .alu_op(alu_op), .alu_s(alu_s), .alu_d(alu_d), .alu_cin(alu_cin), .alu_zin(alu_zin),
    .alu_q(alu_q), .alu_cout(alu_cout), .alu_zout(alu_zout), .exp_sig(exp_sig),
    .sig_valid(sig_valid), .sig_op(sig_op), .sig_value(sig_value),
    .mismatch(mismatch), .done(done)
  );

  // Toy ALU: different behaviour per opcode, one cycle of latency
  function automatic logic [33:0] alu_f(input logic [5:0] op, input logic [31:0] s,
                                        input logic [31:0] d, input logic c, input logic z);
    logic [31:0] q;
    q = (d ^ {s[15:0], s[31:16]}) + ({26'd0, op} * 32'h01000193) + {30'd0, c, z};
    return {(q == 32'd0) ^ z, q[31] ^ c ^ op[0], q};
  endfunction

  always @(posedge clk) begin
    {alu_zout, alu_cout, alu_q} <= alu_f(alu_op, alu_s, alu_d, alu_cin, alu_zin);
  end

  function automatic logic [31:0] tbl(input int i);
    case (i)
      0: return 32'h0;
      1: return 32'h1;
      2: return 32'h2;
      3: return 32'h7FFFFFFF;
      4: return 32'h80000000;
      5: return 32'h80000001;
      6: return 32'hFFFFFFFE;
      default: return 32'hFFFFFFFF;
    endcase
  endfunction

  function automatic logic [31:0] ref_sig(input int op);
    logic [31:0] crc;
    logic [33:0] r;
    crc = 32'hFFFFFFFF;
    for (int v = 0; v < VPO; v++) begin
      r = alu_f(6'(op), tbl(v / 32), tbl((v / 4) % 8), v[1], v[0]);
      for (int b = 0; b < 34; b++) begin
        if (crc[0] ^ r[b]) crc = (crc >> 1) ^ 32'hEDB88320;
        else               crc = crc >> 1;
      end
    end
    return ~crc;
  endfunction

  assign exp_sig = gold[sig_op] ^ ((int'(sig_op) == corrupt) ? 32'h1 : 32'h0);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_quiet(input string tag);
    chk({tag, " alu_op"}, 64'(alu_op), 64'd0);
    chk({tag, " alu_s"},  64'(alu_s), 64'd0);
    chk({tag, " alu_d"},  64'(alu_d), 64'd0);
    chk({tag, " alu_cin"}, 64'(alu_cin), 64'd0);
    chk({tag, " alu_zin"}, 64'(alu_zin), 64'd0);
  endtask

  // One full sweep checked every cycle against the behavioural model
  task automatic sweep(input int corr, input int kick);
    int idx, v, j;
    logic sv_e, done_e, miss_e;
    corrupt = corr;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int k = 1; k <= NOPS * VPO + 6; k++) begin
      idx = k - 1;
      if (k <= NOPS * VPO) begin
        v = idx % VPO;
        chk("R2 alu_op", 64'(alu_op), 64'(FIRST + idx / VPO));
        chk("R3 R4 alu_s", 64'(alu_s), 64'(tbl(v / 32)));
        chk("R3 R4 alu_d", 64'(alu_d), 64'(tbl((v / 4) % 8)));
        chk("R3 alu_cin", 64'(alu_cin), 64'(v[1]));
        chk("R3 alu_zin", 64'(alu_zin), 64'(v[0]));
      end else begin
        chk_quiet("R11");
      end
      sv_e = (k >= VPO + 2) && (((k - 2) % VPO) == 0) && (((k - 2) / VPO) <= NOPS);
      chk("R7 sig_valid", 64'(sig_valid), 64'(sv_e));
      if (sv_e) begin
        j = (k - 2) / VPO - 1;
        chk("R7 sig_op", 64'(sig_op), 64'(FIRST + j));
        chk("R5 R6 sig_value", 64'(sig_value), 64'(gold[FIRST + j]));
      end
      done_e = (k >= NOPS * VPO + 3);
      chk("R9 done", 64'(done), 64'(done_e));
      miss_e = (corr >= 0) && (k >= (corr - FIRST + 1) * VPO + 3);
      chk("R8 mismatch", 64'(mismatch), 64'(miss_e));
      start = (k == kick) ? 1'b1 : 1'b0;   // R10: mid-sweep start must be ignored
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int o = 0; o < 64; o++) gold[o] = (o >= FIRST) ? ref_sig(o) : 32'h0;
    rst_n = 1'b0;
    start = 1'b0;
    repeat (4) @(negedge clk);
    chk_quiet("R1");
    chk("R1 sig_valid", 64'(sig_valid), 64'd0);
    chk("R1 mismatch", 64'(mismatch), 64'd0);
    chk("R1 done", 64'(done), 64'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk_quiet("R1 idle");
    chk("R1 idle done", 64'(done), 64'd0);
    chk("R1 idle sig_op", 64'(sig_op), 64'd0);
    chk("R1 idle sig_value", 64'(sig_value), 64'd0);

    sweep(-1, 1000);        // clean sweep with a stray start mid-way (R10)
    repeat (10) @(negedge clk);
    chk("R9 done holds", 64'(done), 64'd1);
    chk_quiet("R11 after done");

    sweep(LAST, NOPS * VPO + 1); // last opcode wrong, start in drain (R8, R10)
    sweep(20, -1);          // earlier opcode wrong: sticky flag
    sweep(-1, -1);          // restart clears mismatch (R8)

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule